// File: doc/BRIEF.md
# Column-Serial Positional Evaluator

This block computes the detailed part of a chess position score. It takes a snapshot of the whole board when a start pulse is accepted. It then visits the files one per clock, from file 0 to the last file. In each visit, every rank of the current file looks up its piece in its own small table. The table outputs go through a pipelined adder tree into a saturating running sum. A scan register, updated as the files go by from left to right, records per-file pawn presence and doubled-pawn counts. When the running sum is complete, a final stage also looks at each file's right-hand neighbour to find isolated pawns, applies the pawn-structure penalties and delivers a signed score with a one-cycle valid strobe.

Scores are from White's point of view: white material counts as positive and black material as negative. The search controller fires `start`, holds nothing, and waits for `score_valid`. A new evaluation can be accepted in the same cycle that the previous result is presented.

Top module: `colserial_eval`

## Requirements
- R1: While reset is asserted, `score_valid` is 0 and `score` is 0.
- R2: When `start` is accepted at a clock edge, `score_valid` is high for exactly one cycle, after the 11th following edge (8 file steps plus 3 pipeline stages), and at no other time.
- R3: A square holds a 4-bit code: bit 3 is the colour (0 white, 1 black) and bits 2:0 are the kind (0 empty, 1 pawn, 2 knight, 3 bishop, 4 rook, 5 queen, 6 king, 7 treated as empty). A white piece contributes the following: pawn 100 + 8*rank, knight 300, bishop 310, rook 500, queen 900, king 0. Ranks are numbered 0 to 7, and the square index is file*8 + rank, each square taking board bits [4*index+3 : 4*index].
- R4: A black piece contributes the negative of the white value at the mirrored rank (7 - rank).
- R5: The files are summed in order 0 to 7. After each file is added, the running total is clamped to the range -32768..32767, and the final adjusted score is clamped to the same range.
- R6: A `start` that arrives while an evaluation is in flight is ignored. This covers the edges from acceptance through the edge that raises `score_valid`. A `start` in the cycle where `score_valid` is high is accepted.
- R7: Each file holding two or more pawns of one colour costs that colour 20 points, once per file.
- R8: Each file holding pawns of one colour, where neither adjacent file holds pawns of that colour, costs that colour 15 points. Files 0 and 7 have only one neighbour.
- R9: The score depends only on the board value sampled at the accepting edge. Later changes to `board` have no effect.
- R10: `score` changes only at the edge that raises `score_valid` and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to evaluate the board |
| board | input | 256 | Sixty-four 4-bit square codes, index file*8+rank |
| score | output | 16 | Signed positional score, White positive |
| score_valid | output | 1 | One-cycle strobe marking a new score |

## Verification
Each result is due at the 12th falling edge after the falling edge where the bench raises `start`: the start is accepted at the next rising edge, and the strobe rises 11 edges after that. The driver stores this due cycle with the expected score in the scoreboard. The monitor checks both the timing and the value when the strobe appears, and it flags a missing strobe once the due cycle has passed. An ignored start pushes nothing, so any extra strobe finds an empty queue and is reported.

// File: rtl/cse_pkg.sv
package cse_pkg;

   localparam int CODE_W = 4;

   typedef enum logic [2:0] {
      KIND_NONE   = 3'd0,
      KIND_PAWN   = 3'd1,
      KIND_KNIGHT = 3'd2,
      KIND_BISHOP = 3'd3,
      KIND_ROOK   = 3'd4,
      KIND_QUEEN  = 3'd5,
      KIND_KING   = 3'd6,
      KIND_SPARE  = 3'd7
   } kind_e;

   localparam int VAL_KNIGHT = 300;
   localparam int VAL_BISHOP = 310;
   localparam int VAL_ROOK   = 500;
   localparam int VAL_QUEEN  = 900;

   // Placement value of one square code at one rank, White positive.
   function automatic int piece_score(input logic [CODE_W-1:0] code,
                                      input int rank, input int ranks,
                                      input int pbase, input int pstep);
      int v;
      int r;
      r = code[CODE_W-1] ? (ranks - 1 - rank) : rank;
      case (kind_e'(code[2:0]))
         KIND_PAWN:   v = pbase + pstep * r;
         KIND_KNIGHT: v = VAL_KNIGHT;
         KIND_BISHOP: v = VAL_BISHOP;
         KIND_ROOK:   v = VAL_ROOK;
         KIND_QUEEN:  v = VAL_QUEEN;
         default:     v = 0;
      endcase
      return code[CODE_W-1] ? -v : v;
   endfunction

endpackage

// File: rtl/cse_lane_tab.sv
module cse_lane_tab
   import cse_pkg::*;
#(
   parameter int SCORE_W   = 16,
   parameter int RANK      = 0,
   parameter int RANKS     = 8,
   parameter int PAWN_BASE = 100,
   parameter int PAWN_STEP = 8
) (
   input  logic [CODE_W-1:0]         code,
   output logic signed [SCORE_W-1:0] val,
   output logic                      w_pawn,
   output logic                      b_pawn
);
   localparam int ENTRIES = 2 ** CODE_W;

   logic signed [SCORE_W-1:0] tab [ENTRIES];

   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      assign tab[i] = SCORE_W'(piece_score(CODE_W'(i), RANK, RANKS,
                                           PAWN_BASE, PAWN_STEP));
   end

   assign val    = tab[code];
   assign w_pawn = (code == {1'b0, KIND_PAWN});
   assign b_pawn = (code == {1'b1, KIND_PAWN});

endmodule

// File: rtl/cse_ctrl.sv
module cse_ctrl #(
   parameter int FILES  = 8,
   parameter int BOARD_W = 256,
   localparam int COL_W = $clog2(FILES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [BOARD_W-1:0] board_in,
   input  logic               done,
   output logic [BOARD_W-1:0] board_q,
   output logic [COL_W-1:0]   col,
   output logic               scan_on,
   output logic               busy
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         scan_on <= 1'b0;
         col     <= '0;
         board_q <= '0;
      end else if (start && !busy) begin
         busy    <= 1'b1;
         scan_on <= 1'b1;
         col     <= '0;
         board_q <= board_in;
      end else begin
         if (done) busy <= 1'b0;
         if (scan_on) begin
            if (col == COL_W'(FILES - 1)) begin
               col     <= '0;
               scan_on <= 1'b0;
            end else begin
               col <= col + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/cse_sum_tree.sv
module cse_sum_tree #(
   parameter int RANKS   = 8,
   parameter int SCORE_W = 16,
   parameter bit SAT_EN  = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      go,
   input  logic                      first,
   input  logic                      last,
   input  logic signed [SCORE_W-1:0] lane_val [RANKS],
   output logic signed [SCORE_W-1:0] acc,
   output logic                      acc_done
);
   localparam int HALF = RANKS / 2;
   localparam int HI   = (1 <<< (SCORE_W - 1)) - 1;
   localparam int LO   = -(1 <<< (SCORE_W - 1));

   logic signed [SCORE_W-1:0] lane_q [RANKS];
   logic signed [SCORE_W-1:0] part_q [2];
   logic v1, f1, l1, v2, f2, l2;
   int   half_sum [2];
   int   acc_sum;
   logic signed [SCORE_W-1:0] acc_nxt;

   // stage 1: register the table outputs of the current file
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < RANKS; i++) lane_q[i] <= '0;
         v1 <= 1'b0; f1 <= 1'b0; l1 <= 1'b0;
      end else begin
         if (go) for (int i = 0; i < RANKS; i++) lane_q[i] <= lane_val[i];
         v1 <= go;
         f1 <= go && first;
         l1 <= go && last;
      end
   end

   always_comb begin
      for (int h = 0; h < 2; h++) begin
         half_sum[h] = 0;
         for (int i = 0; i < HALF; i++) half_sum[h] += int'(lane_q[h*HALF + i]);
      end
   end

   // stage 2: two partial sums
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         part_q[0] <= '0; part_q[1] <= '0;
         v2 <= 1'b0; f2 <= 1'b0; l2 <= 1'b0;
      end else begin
         if (v1) begin
            part_q[0] <= SCORE_W'(half_sum[0]);
            part_q[1] <= SCORE_W'(half_sum[1]);
         end
         v2 <= v1;
         f2 <= f1;
         l2 <= l1;
      end
   end

   assign acc_sum = (f2 ? 0 : int'(acc)) + int'(part_q[0]) + int'(part_q[1]);

   if (SAT_EN) begin : g_sat
      always_comb begin
         if (acc_sum > HI)      acc_nxt = SCORE_W'(HI);
         else if (acc_sum < LO) acc_nxt = SCORE_W'(LO);
         else                   acc_nxt = SCORE_W'(acc_sum);
      end
   end else begin : g_wrap
      assign acc_nxt = SCORE_W'(acc_sum);
   end

   // stage 3: running total across files
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc      <= '0;
         acc_done <= 1'b0;
      end else begin
         if (v2) acc <= acc_nxt;
         acc_done <= v2 && l2;
      end
   end

endmodule

// File: rtl/cse_file_scan.sv
module cse_file_scan #(
   parameter int FILES = 8,
   parameter int RANKS = 8,
   localparam int CW   = $clog2(RANKS + 1),
   localparam int FW   = $clog2(FILES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic             first,
   input  logic [CW-1:0]    w_cnt,
   input  logic [CW-1:0]    b_cnt,
   output logic [FILES-1:0] w_map,
   output logic [FILES-1:0] b_map,
   output logic [FW-1:0]    w_dbl,
   output logic [FW-1:0]    b_dbl
);
   // Shifting in at the top: after a full pass, file f lands in bit f.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         w_map <= '0;
         b_map <= '0;
         w_dbl <= '0;
         b_dbl <= '0;
      end else if (go) begin
         w_map <= {(w_cnt != '0), w_map[FILES-1:1]};
         b_map <= {(b_cnt != '0), b_map[FILES-1:1]};
         w_dbl <= (first ? '0 : w_dbl) + FW'(w_cnt >= CW'(2));
         b_dbl <= (first ? '0 : b_dbl) + FW'(b_cnt >= CW'(2));
      end
   end

endmodule

// File: rtl/cse_merge.sv
module cse_merge #(
   parameter int FILES   = 8,
   parameter int SCORE_W = 16,
   parameter int DBL_PEN = 20,
   parameter int ISO_PEN = 15,
   parameter bit SAT_EN  = 1'b1,
   localparam int FW     = $clog2(FILES + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      done,
   input  logic signed [SCORE_W-1:0] acc,
   input  logic [FILES-1:0]          w_map,
   input  logic [FILES-1:0]          b_map,
   input  logic [FW-1:0]             w_dbl,
   input  logic [FW-1:0]             b_dbl,
   output logic signed [SCORE_W-1:0] score,
   output logic                      score_valid
);
   localparam int HI = (1 <<< (SCORE_W - 1)) - 1;
   localparam int LO = -(1 <<< (SCORE_W - 1));

   logic [FILES+1:0] w_pad, b_pad;
   logic [FILES-1:0] w_iso, b_iso;
   int   pen, fin;
   logic signed [SCORE_W-1:0] fin_v;

   assign w_pad = {1'b0, w_map, 1'b0};
   assign b_pad = {1'b0, b_map, 1'b0};

   // neighbour on both sides: the right-hand bit is only known after the scan
   for (genvar f = 0; f < FILES; f++) begin : g_iso
      assign w_iso[f] = w_pad[f+1] & ~w_pad[f] & ~w_pad[f+2];
      assign b_iso[f] = b_pad[f+1] & ~b_pad[f] & ~b_pad[f+2];
   end

   assign pen = DBL_PEN * (int'(w_dbl) - int'(b_dbl))
              + ISO_PEN * ($countones(w_iso) - $countones(b_iso));
   assign fin = int'(acc) - pen;

   if (SAT_EN) begin : g_sat
      always_comb begin
         if (fin > HI)      fin_v = SCORE_W'(HI);
         else if (fin < LO) fin_v = SCORE_W'(LO);
         else               fin_v = SCORE_W'(fin);
      end
   end else begin : g_wrap
      assign fin_v = SCORE_W'(fin);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         score       <= '0;
         score_valid <= 1'b0;
      end else begin
         score_valid <= done;
         if (done) score <= fin_v;
      end
   end

endmodule

// File: rtl/colserial_eval.sv
module colserial_eval
   import cse_pkg::*;
#(
   parameter int FILES     = 8,
   parameter int RANKS     = 8,
   parameter int SCORE_W   = 16,
   parameter int PAWN_BASE = 100,
   parameter int PAWN_STEP = 8,
   parameter int DBL_PEN   = 20,
   parameter int ISO_PEN   = 15,
   parameter bit SAT_EN    = 1'b1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              start,
   input  logic [FILES*RANKS*CODE_W-1:0]     board,
   output logic signed [SCORE_W-1:0]         score,
   output logic                              score_valid
);
   localparam int BOARD_W = FILES * RANKS * CODE_W;
   localparam int FILE_W  = RANKS * CODE_W;
   localparam int COL_W   = $clog2(FILES);
   localparam int CW      = $clog2(RANKS + 1);
   localparam int FW      = $clog2(FILES + 1);

   if (SCORE_W < 14 || SCORE_W > 30) begin : g_bad_width
      $error("SCORE_W must lie in 14..30");
   end
   if (RANKS < 2 || (RANKS % 2) != 0) begin : g_bad_ranks
      $error("RANKS must be even and at least 2");
   end
   if (FILES < 2) begin : g_bad_files
      $error("FILES must be at least 2");
   end

   logic [BOARD_W-1:0]        board_q;
   logic [COL_W-1:0]          col;
   logic                      scan_on, busy, acc_done;
   logic [FILE_W-1:0]         file_slot [FILES];
   logic [FILE_W-1:0]         cur_file;
   logic signed [SCORE_W-1:0] lane_val [RANKS];
   logic [RANKS-1:0]          wp, bp;
   logic [CW-1:0]             w_cnt, b_cnt;
   logic signed [SCORE_W-1:0] acc;
   logic [FILES-1:0]          w_map, b_map;
   logic [FW-1:0]             w_dbl, b_dbl;
   logic                      first_col, last_col;

   cse_ctrl #(.FILES(FILES), .BOARD_W(BOARD_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .board_in(board),
      .done(acc_done), .board_q(board_q), .col(col),
      .scan_on(scan_on), .busy(busy)
   );

   for (genvar f = 0; f < FILES; f++) begin : g_file
      assign file_slot[f] = board_q[f*FILE_W +: FILE_W];
   end
   assign cur_file  = file_slot[col];
   assign first_col = (col == '0);
   assign last_col  = (col == COL_W'(FILES - 1));

   for (genvar r = 0; r < RANKS; r++) begin : g_lane
      cse_lane_tab #(
         .SCORE_W(SCORE_W), .RANK(r), .RANKS(RANKS),
         .PAWN_BASE(PAWN_BASE), .PAWN_STEP(PAWN_STEP)
      ) u_tab (
         .code(cur_file[r*CODE_W +: CODE_W]),
         .val(lane_val[r]), .w_pawn(wp[r]), .b_pawn(bp[r])
      );
   end

   assign w_cnt = CW'($countones(wp));
   assign b_cnt = CW'($countones(bp));

   cse_sum_tree #(.RANKS(RANKS), .SCORE_W(SCORE_W), .SAT_EN(SAT_EN)) u_tree (
      .clk(clk), .rst_n(rst_n), .go(scan_on), .first(first_col),
      .last(last_col), .lane_val(lane_val), .acc(acc), .acc_done(acc_done)
   );

   cse_file_scan #(.FILES(FILES), .RANKS(RANKS)) u_scan (
      .clk(clk), .rst_n(rst_n), .go(scan_on), .first(first_col),
      .w_cnt(w_cnt), .b_cnt(b_cnt), .w_map(w_map), .b_map(b_map),
      .w_dbl(w_dbl), .b_dbl(b_dbl)
   );

   cse_merge #(
      .FILES(FILES), .SCORE_W(SCORE_W), .DBL_PEN(DBL_PEN),
      .ISO_PEN(ISO_PEN), .SAT_EN(SAT_EN)
   ) u_merge (
      .clk(clk), .rst_n(rst_n), .done(acc_done), .acc(acc),
      .w_map(w_map), .b_map(b_map), .w_dbl(w_dbl), .b_dbl(b_dbl),
      .score(score), .score_valid(score_valid)
   );

endmodule

// File: rtl/colserial_eval_chk.sv
module colserial_eval_chk #(
   parameter int FILES   = 8,
   parameter int SCORE_W = 16
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      start,
   input logic signed [SCORE_W-1:0] score,
   input logic                      score_valid
);
   localparam int DUE   = FILES + 4;
   localparam int RUN_W = $clog2(FILES + 5);

   // 0 idle; 1 after the accepting edge; DUE while the result is shown
   logic [RUN_W-1:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_cnt <= '0;
      else if (start && (run_cnt == '0 || run_cnt == RUN_W'(DUE))) run_cnt <= RUN_W'(1);
      else if (run_cnt == RUN_W'(DUE)) run_cnt <= '0;
      else if (run_cnt != '0) run_cnt <= run_cnt + 1'b1;
   end

   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |-> (!score_valid && score == '0));

   a_r2_result_due: assert property (@(posedge clk) disable iff (!rst_n)
      (run_cnt == RUN_W'(DUE)) |-> score_valid);

   // R6: a strobe only where an accepted start predicts one
   a_r6_no_extra_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      score_valid |-> (run_cnt == RUN_W'(DUE)));

   a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      score_valid |=> !score_valid);

   a_r10_score_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(score) |-> score_valid);

endmodule

bind colserial_eval colserial_eval_chk #(.FILES(FILES), .SCORE_W(SCORE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .score(score),
   .score_valid(score_valid)
);

// File: tb/sim_colserial_eval.sv
`timescale 1ns/1ps
module sim_colserial_eval;

   typedef struct {
      int     exp;
      longint due;
      string  tag;
   } item_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [255:0] board = '0;
   logic signed [15:0] score;
   logic         score_valid;

   item_t  sb [$];
   longint cyc = 0;
   int     n_chk = 0;
   int     n_err = 0;
   bit     mon_on = 1'b0;
   bit     have_last = 1'b0;
   logic signed [15:0] last_score = '0;
   logic [31:0] lf = 32'h1F3C_9A57;

   colserial_eval u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .board(board),
      .score(score), .score_valid(score_valid)
   );

   always #2 clk = ~clk;
   always @(posedge clk) cyc++;

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic finish_up();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   // ---------------- reference from the requirements ----------------
   function automatic int sq_val(input logic [3:0] c, input int r);
      int re, v;
      re = c[3] ? 7 - r : r;
      case (c[2:0])
         3'd1: v = 100 + 8 * re;
         3'd2: v = 300;
         3'd3: v = 310;
         3'd4: v = 500;
         3'd5: v = 900;
         default: v = 0;
      endcase
      return c[3] ? -v : v;
   endfunction

   function automatic int clamp16(input int x);
      if (x > 32767) return 32767;
      if (x < -32768) return -32768;
      return x;
   endfunction

   function automatic int ref_score(input logic [255:0] b);
      int acc, pen, cs;
      int wc [8];
      int bc [8];
      acc = 0;
      pen = 0;
      for (int f = 0; f < 8; f++) begin
         cs = 0; wc[f] = 0; bc[f] = 0;
         for (int r = 0; r < 8; r++) begin
            logic [3:0] c;
            c = b[(f*8 + r)*4 +: 4];
            cs += sq_val(c, r);
            if (c == 4'b0001) wc[f]++;
            if (c == 4'b1001) bc[f]++;
         end
         acc = clamp16(acc + cs);
      end
      for (int f = 0; f < 8; f++) begin
         bit wl, wr, bl, br;
         wl = (f > 0) && wc[f-1] > 0;  wr = (f < 7) && wc[f+1] > 0;
         bl = (f > 0) && bc[f-1] > 0;  br = (f < 7) && bc[f+1] > 0;
         if (wc[f] >= 2) pen += 20;
         if (bc[f] >= 2) pen -= 20;
         if (wc[f] > 0 && !wl && !wr) pen += 15;
         if (bc[f] > 0 && !bl && !br) pen -= 15;
      end
      return clamp16(acc - pen);
   endfunction

   function automatic logic [255:0] put(input logic [255:0] b, input int f,
                                        input int r, input logic [3:0] c);
      logic [255:0] o;
      o = b;
      o[(f*8 + r)*4 +: 4] = c;
      return o;
   endfunction

   task automatic step_rng();
      lf ^= lf << 13;
      lf ^= lf >> 17;
      lf ^= lf << 5;
   endtask

   task automatic rand_board(output logic [255:0] b);
      logic [3:0] c;
      b = '0;
      for (int s = 0; s < 64; s++) begin
         step_rng();
         c = 4'd0;
         if (lf[9:8] == 2'd0)      c = {lf[10], 3'b001};
         else if (lf[1:0] == 2'd0) c = lf[7:4];
         if (c[2:0] == 3'd7) c = 4'd0;
         b[s*4 +: 4] = c;
      end
   endtask

   // ---------------- driver: call right after a falling edge ----------------
   task automatic run(input logic [255:0] b, input int exp, input string tag,
                      input bit mess);
      item_t it;
      board = b;
      start = 1'b1;
      it.exp = exp; it.due = cyc + 12; it.tag = tag;
      sb.push_back(it);
      @(negedge clk);
      start = 1'b0;
      if (mess) begin
         step_rng();
         board = {8{lf}};
      end
      repeat (11) @(negedge clk);
   endtask

   // ---------------- monitor ----------------
   always @(negedge clk) begin
      if (mon_on) begin
         if (score_valid) begin
            if (sb.size() == 0) begin
               check("R6 unexpected strobe", 1, 0);
            end else begin
               item_t it;
               it = sb.pop_front();
               check({"R2 strobe cycle ", it.tag}, int'(cyc), int'(it.due));
               check({"score ", it.tag}, int'(score), it.exp);
            end
            last_score = score;
            have_last = 1'b1;
         end else begin
            if (sb.size() > 0 && cyc > sb[0].due) begin
               item_t it;
               it = sb.pop_front();
               check({"R2 missing strobe ", it.tag}, 0, 1);
            end
            if (have_last) check("R10 score held", int'(score), int'(last_score));
         end
      end
   end

   initial begin
      #(4 * 150000);
      check("R2 watchdog expired", 0, 1);
      finish_up();
   end

   initial begin
      logic [255:0] b, b2;
      repeat (3) @(negedge clk);
      check("R1 valid in reset", int'(score_valid), 0);
      check("R1 score in reset", int'(score), 0);
      rst_n = 1'b1;
      mon_on = 1'b1;
      @(negedge clk);

      // R3: empty board and single pieces
      run('0, 0, "R3 empty", 1'b0);
      run(put('0, 3, 2, 4'h2), 300, "R3 knight", 1'b0);
      run(put('0, 3, 1, 4'h1), 93, "R3 R8 lone pawn 108-15", 1'b0);
      run(put(put('0, 0, 0, 4'h4), 7, 7, 4'hD), -400, "R4 rook vs queen", 1'b0);
      // R4: black pawn at rank 6 mirrors a white pawn at rank 1
      run(put('0, 4, 6, 4'h9), -93, "R4 black pawn", 1'b0);
      run(put(put('0, 1, 2, 4'h1), 1, 5, 4'h9), 0, "R4 mirror cancels", 1'b0);

      // R7: doubled pawns
      b = put(put(put('0, 2, 1, 4'h1), 2, 2, 4'h1), 3, 1, 4'h1);
      run(b, 312, "R7 white doubled", 1'b0);
      run(put(put('0, 5, 6, 4'h9), 5, 5, 4'h9), -189, "R7 black doubled", 1'b0);

      // R8: isolation incl. edge files
      run(put(put('0, 0, 1, 4'h1), 2, 1, 4'h1), 186, "R8 edge and middle", 1'b0);
      run(put('0, 7, 1, 4'h1), 93, "R8 last file", 1'b0);

      // R5: saturation, and order of clamping
      b = '0; b2 = '0;
      for (int s = 0; s < 64; s++) begin
         b[s*4 +: 4]  = 4'h5;
         b2[s*4 +: 4] = 4'hD;
      end
      run(b, 32767, "R5 all white queens", 1'b0);
      run(b2, -32768, "R5 all black queens", 1'b0);
      b = '0;
      for (int s = 0; s < 64; s++) b[s*4 +: 4] = (s < 40) ? 4'h5 : 4'hD;
      run(b, 11167, "R5 clamp then descend", 1'b0);

      // R9: board changes right after acceptance
      b = put(put('0, 4, 0, 4'h3), 6, 3, 4'h1);
      run(b, ref_score(b), "R9 board scrambled", 1'b1);

      // R6: start held high across a whole run, different boards
      b  = put('0, 2, 2, 4'h2);
      b2 = put('0, 5, 5, 4'hC);
      board = b;
      start = 1'b1;
      begin
         item_t it;
         it.exp = 300; it.due = cyc + 12; it.tag = "R6 first accepted";
         sb.push_back(it);
      end
      repeat (11) begin
         @(negedge clk);
         board = put('0, 0, 0, 4'h5);
      end
      @(negedge clk);
      board = b2;
      begin
         item_t it;
         it.exp = -500; it.due = cyc + 12; it.tag = "R6 accepted on strobe";
         sb.push_back(it);
      end
      @(negedge clk);
      start = 1'b0;
      repeat (11) @(negedge clk);

      // random boards, back to back
      for (int k = 0; k < 24; k++) begin
         rand_board(b);
         run(b, ref_score(b), "R3 R4 R7 R8 random", k[0]);
      end

      repeat (20) @(negedge clk);
      check("R2 scoreboard drained", sb.size(), 0);
      finish_up();
   end

endmodule